// File: doc/BRIEF.md
# Tear-Free Wide Register Byte Bridge

This block sits between an 8-bit host bus and a set of 16-bit registers belonging to one timer unit: a free-running count, two compare values and a captured value. The host reaches each wide register through two byte addresses. A single shared holding byte lets a full 16-bit value be read or written as one atomic operation, even though the host can only move one byte per access.

To write, the host first stores the upper byte, which lands only in the holding byte. It then stores the lower byte, which produces a one-cycle write strobe toward the chosen register with the full word. To read, the host first reads the lower byte. That read returns the low half and, at the same clock edge, snapshots the upper half into the holding byte. A later upper-byte read returns the snapshot. The two compare registers are the exception: their upper byte is read straight from the register and leaves the holding byte alone. The registers themselves live outside the block. It decodes addresses, keeps the holding byte, steers read data and generates write strobes. Software must keep interrupts from disturbing the holding byte between the two halves of an access.

Top module: `wide_byte_bridge`

## Requirements
- R1: After reset the holding byte is 0x00, so an upper-byte read of the count register (address 1) returns 0x00.
- R2: A write to an upper-byte address loads the holding byte at the next clock edge and raises no write strobe.
- R3: A write to a lower-byte address raises, in the same cycle, exactly one strobe bit (bit = register index) with write data {holding byte, written byte`}`, and leaves the holding byte unchanged.
- R4: A read of a lower-byte address returns that register's bits 7:0 in the same cycle and loads its bits 15:8 into the holding byte at the next clock edge.
- R5: A read of the upper byte of the count register (index 0) or the capture register (index 3) returns the holding byte and does not change it.
- R6: A read of the upper byte of compare register A (index 1) or B (index 2) returns that register's bits 15:8 directly and does not change the holding byte.
- R7: The holding byte is shared: a lower-byte read of one register followed by an upper-byte read of another non-compare register returns the first register's upper byte.
- R8: With neither read nor write requested, read data is 0x00, no strobe is raised and the holding byte is unchanged.
- R9: When read and write are requested in the same cycle, the write alone takes effect: read data is 0x00 and the read has no effect on the holding byte.
- R10: Address bit 0 selects the byte (0 = bits 7:0, 1 = bits 15:8) and address bits 2:1 select the register (0 count, 1 compare A, 2 compare B, 3 capture). Every mix of address and operation follows R2 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Byte address: bit 0 byte select, bits 2:1 register index |
| host_wr | input | 1 | Write request for this cycle |
| host_rd | input | 1 | Read request for this cycle |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, combinational on address and request |
| reg_rd_data | input | 64 | Current values of the four wide registers, register i in bits 16i+15:16i |
| reg_wr_stb | output | 4 | One-hot write strobe, one bit per wide register |
| reg_wr_data | output | 16 | Word to be written when a strobe is high |

## Verification
Read data, strobes and write data are due in the same cycle as the request. The bench drives each request just after a falling edge and samples those outputs one nanosecond later, well before the next rising edge. Changes to the holding byte take effect at that rising edge and can only be seen through a later upper-byte read. So every holding-byte expectation is checked on a following access, never on the request that caused it. The bench's model of the outer registers commits strobed words one nanosecond after the rising edge, so it cannot race the bridge's own sampling of those registers.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ACC_IDLE  = 3'd0,
    ACC_WR_HI = 3'd1,
    ACC_WR_LO = 3'd2,
    ACC_RD_HI = 3'd3,
    ACC_RD_LO = 3'd4
  } acc_kind_t;

  // Whether a register index reads its upper byte directly (bypass mask).
  function automatic logic is_direct(input int unsigned idx, input logic [31:0] mask);
    return mask[idx];
  endfunction

  function automatic logic [WORD_W-1:0] join_word(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] upper_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lower_of(input logic [WORD_W-1:0] w);
    return w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/wbb_decode.sv
module wbb_decode
  import wbb_pkg::*;
#(
  parameter int NREG  = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW    = IDX_W + 1
) (
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic             rd,
  output acc_kind_t        kind,
  output logic [IDX_W-1:0] idx
);
  logic hi_sel;
  logic idx_ok;

  assign hi_sel = addr[0];
  assign idx    = addr[AW-1:1];
  assign idx_ok = (int'(idx) < NREG);

  always_comb begin
    kind = ACC_IDLE;
    if (idx_ok) begin
      if (wr)      kind = hi_sel ? ACC_WR_HI : ACC_WR_LO;
      else if (rd) kind = hi_sel ? ACC_RD_HI : ACC_RD_LO;
    end
  end
endmodule

// File: rtl/wbb_hold.sv
module wbb_hold
  import wbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_t         kind,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] sel_upper,
  output logic [BYTE_W-1:0] hold,
  output logic              ev_load_wr,
  output logic              ev_load_rd
);
  assign ev_load_wr = (kind == ACC_WR_HI);
  assign ev_load_rd = (kind == ACC_RD_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold <= '0;
    else if (ev_load_wr) hold <= wdata;
    else if (ev_load_rd) hold <= sel_upper;
  end

  // R2: upper-byte write lands in the holding byte
  p_hold_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_WR_HI) |=> (hold == $past(wdata)));

  // R4: lower-byte read snapshots the register's upper byte
  p_hold_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_RD_LO) |=> (hold == $past(sel_upper)));

  // R5/R6/R3/R8: every other access keeps the holding byte
  p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_RD_HI || kind == ACC_WR_LO || kind == ACC_IDLE) |=> $stable(hold));
endmodule

// File: rtl/wbb_readmux.sv
module wbb_readmux
  import wbb_pkg::*;
#(
  parameter int          NREG        = 4,
  parameter logic [31:0] DIRECT_MASK = 32'h6,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  acc_kind_t                kind,
  input  logic [IDX_W-1:0]         idx,
  input  logic [NREG*WORD_W-1:0]   words,
  input  logic [BYTE_W-1:0]        hold,
  output logic [WORD_W-1:0]        sel_word,
  output logic [BYTE_W-1:0]        rdata,
  output logic                     ev_direct
);
  logic [WORD_W-1:0] word_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign word_arr[g] = words[g*WORD_W +: WORD_W];
  end

  assign sel_word  = (int'(idx) < NREG) ? word_arr[idx] : '0;
  assign ev_direct = (kind == ACC_RD_HI) && is_direct(int'(idx), DIRECT_MASK);

  always_comb begin
    unique case (kind)
      ACC_RD_LO: rdata = lower_of(sel_word);
      ACC_RD_HI: rdata = ev_direct ? upper_of(sel_word) : hold;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/wide_byte_bridge.sv
module wide_byte_bridge
  import wbb_pkg::*;
#(
  parameter int          NREG        = 4,
  parameter logic [31:0] DIRECT_MASK = 32'h6,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW    = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            host_addr,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [BYTE_W-1:0]        host_wdata,
  output logic [BYTE_W-1:0]        host_rdata,
  input  logic [NREG*WORD_W-1:0]   reg_rd_data,
  output logic [NREG-1:0]          reg_wr_stb,
  output logic [WORD_W-1:0]        reg_wr_data
);
  acc_kind_t         kind;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] hold;
  logic [WORD_W-1:0] sel_word;
  logic              ev_load_wr, ev_load_rd, ev_direct, ev_commit;

  wbb_decode #(.NREG(NREG)) u_decode (
    .addr(host_addr), .wr(host_wr), .rd(host_rd), .kind(kind), .idx(idx)
  );

  wbb_readmux #(.NREG(NREG), .DIRECT_MASK(DIRECT_MASK)) u_readmux (
    .kind(kind), .idx(idx), .words(reg_rd_data), .hold(hold),
    .sel_word(sel_word), .rdata(host_rdata), .ev_direct(ev_direct)
  );

  wbb_hold u_hold (
    .clk(clk), .rst_n(rst_n), .kind(kind), .wdata(host_wdata),
    .sel_upper(upper_of(sel_word)), .hold(hold),
    .ev_load_wr(ev_load_wr), .ev_load_rd(ev_load_rd)
  );

  assign ev_commit   = (kind == ACC_WR_LO);
  assign reg_wr_data = join_word(hold, host_wdata);

  for (genvar g = 0; g < NREG; g++) begin : g_stb
    assign reg_wr_stb[g] = ev_commit && (int'(idx) == g);
  end

  // R3: at most one register is strobed
  p_stb_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr_stb));

  // R3: a lower-byte write strobes exactly one register
  p_stb_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr[0]) |-> ($countones(reg_wr_stb) == 1));

  // R2: an upper-byte write never strobes
  p_no_stb_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr[0]) |-> (reg_wr_stb == '0));

  // R8: an idle bus is quiet
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !host_rd) |-> (reg_wr_stb == '0 && host_rdata == '0));

  // R9: a write cycle returns no read data
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |-> (host_rdata == '0));

  // R6: a direct upper read leaves the holding byte alone
  p_direct_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_direct |=> $stable(hold));
endmodule

// File: tb/wide_byte_bridge_tb.sv
module wide_byte_bridge_tb;
  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [63:0] reg_rd_data;
  logic [3:0]  reg_wr_stb;
  logic [15:0] reg_wr_data;

  logic [15:0] model [4];
  logic [7:0]  exp_hold;
  item_t       q [$];
  event        sample_ev;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign reg_rd_data = {model[3], model[2], model[1], model[0]};

  wide_byte_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_rd_data(reg_rd_data), .reg_wr_stb(reg_wr_stb), .reg_wr_data(reg_wr_data)
  );

  // Monitor: pops every queued expectation and compares with the ports.
  always @(sample_ev) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.sel)
        1:       act = {12'd0, reg_wr_stb};
        2:       act = reg_wr_data;
        default: act = {8'd0, host_rdata};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  // Driver: one bus cycle; expectations derived from the requirement rules.
  task automatic step(input bit rd, input bit wr, input logic [2:0] a,
                      input logic [7:0] d, input string req, input int lit = -1);
    bit hi;
    int idx;
    logic [7:0] e_rd;
    logic [3:0] e_stb;
    logic [7:0] nxt_hold;
    hi = a[0];
    idx = int'(a[2:1]);
    e_rd = 8'h00;
    e_stb = 4'h0;
    nxt_hold = exp_hold;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
    if (wr) begin
      if (hi) nxt_hold = d;
      else e_stb = 4'b0001 << idx;
    end else if (rd) begin
      if (!hi) begin
        e_rd = model[idx][7:0];
        nxt_hold = model[idx][15:8];
      end else if (idx == 1 || idx == 2) e_rd = model[idx][15:8];
      else e_rd = exp_hold;
    end
    q.push_back('{0, {8'd0, e_rd}, req});
    q.push_back('{1, {12'd0, e_stb}, req});
    if (wr && !hi) q.push_back('{2, {exp_hold, d}, req});
    if (lit >= 0) q.push_back('{3, 16'(lit), req});
    #1;
    ->sample_ev;
    @(posedge clk);
    #1;
    if (wr && !hi) model[idx] = {exp_hold, d};
    exp_hold = nxt_hold;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 16'h0000;
    model[2] = 16'hC3A5;
    exp_hold = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: holding byte cleared by reset
    step(1, 0, 3'd1, 8'h00, "R1 reset hold", 8'h00);
    step(1, 0, 3'd7, 8'h00, "R1 reset hold capture", 8'h00);
    // R8: idle
    step(0, 0, 3'd2, 8'hFF, "R8 idle", 8'h00);
    step(1, 0, 3'd1, 8'h00, "R8 hold unchanged", 8'h00);
    // R2 then R3: write compare A as 0x1234
    step(0, 1, 3'd3, 8'h12, "R2 upper write");
    step(0, 1, 3'd2, 8'h34, "R3 lower write commit");
    step(1, 0, 3'd1, 8'h00, "R3 hold after commit", 8'h12);
    // R6: direct upper read of compare A
    step(1, 0, 3'd3, 8'h00, "R6 direct compare A", 8'h12);
    // R4 and R5: count register
    model[0] = 16'hABCD;
    step(1, 0, 3'd0, 8'h00, "R4 lower read", 8'hCD);
    step(1, 0, 3'd1, 8'h00, "R5 upper from hold", 8'hAB);
    // R7: shared hold across registers
    model[3] = 16'h5678;
    step(1, 0, 3'd6, 8'h00, "R7 capture lower", 8'h78);
    step(1, 0, 3'd1, 8'h00, "R7 shared hold", 8'h56);
    // R6: compare B direct read keeps hold
    step(1, 0, 3'd5, 8'h00, "R6 direct compare B", 8'hC3);
    step(1, 0, 3'd7, 8'h00, "R6 hold kept", 8'h56);
    // R9: simultaneous read and write
    step(1, 1, 3'd1, 8'h9A, "R9 write wins", 8'h00);
    step(1, 0, 3'd7, 8'h00, "R9 hold from write", 8'h9A);
    step(1, 1, 3'd4, 8'h11, "R9 lower write with read", 8'h00);
    step(1, 0, 3'd5, 8'h00, "R9 compare B committed", 8'h9A);
    // R10: mixed traffic on all addresses
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[15:12] == 4'd0) model[0] = r[31:16];
      if (r[15:12] == 4'd1) model[3] = r[31:16];
      step(r[8], r[9], r[2:0], r[23:16], "R10 mixed");
    end
    @(negedge clk);
    host_rd = 0; host_wr = 0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule